// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous, single-clock request port and an external asynchronous static RAM of 128K bytes. A requester presents a read or a write with a valid/ready handshake. The controller then produces the chip-select, write-strobe and output-enable sequence the memory expects. Every minimum time of the memory is a parameter in nanoseconds, and the controller turns it into a whole number of clock cycles.

The memory's bidirectional data pins are presented as three separate signals: outgoing data, incoming data and a drive enable. The surrounding pad logic builds the tristate from them. While no access is in progress, the memory is kept deselected. The controller does not drive the bus while the memory's outputs may still be active. This covers the early part of the write-strobe low time, and the release time after a read when a write follows it.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and in every cycle where `req_ready` is 1, the memory is in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access ends. A request offered while `req_ready` is 0 has no effect on the memory contents.
- R3: A read (`req_write`=0) holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1, with a constant `mem_addr`. This lasts exactly ceil(max(T_RC,T_AA)/CLK_NS) cycles, and never less than one cycle. `mem_we_n` and `mem_oe_n` are never both 0.
- R4: Read data is taken from `mem_dq_in` on the edge that ends the read window. It appears on `rd_data` with `rd_valid`=1 for exactly one cycle.
- R5: A write (`req_write`=1) selects the chip, keeps `mem_oe_n`=1 and holds `mem_we_n` low with a constant `mem_addr` for WL cycles. WL is the largest of ceil(T_WP/P), ceil(T_AW/P), ceil(T_WC/P) and ceil(T_HZWE/P)+ceil(T_DS/P), where P is CLK_NS.
- R6: During a write, `mem_dq_oe` stays 0 for the first ceil(T_HZWE/P) cycles after `mem_we_n` falls. It then stays 1 until `mem_we_n` rises, which gives a data setup of at least T_DS. It returns to 0 on the same edge where `mem_we_n` rises.
- R7: A write accepted directly after a read is preceded by ceil(T_HZOE/P) deselected cycles before `mem_we_n` falls. Without a preceding read, `mem_we_n` falls in the cycle after acceptance. In both cases `mem_dq_oe` never rises before T_HZOE has passed since `mem_oe_n` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Chip enable 1, active low |
| mem_ce2 | output | 1 | Chip enable 2, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The cycle that returns read data (`rd_valid`) is also the first cycle with `req_ready` high again. A write waiting behind a read is therefore accepted in that same cycle, and the read-to-write turnaround starts at that point. The bench queues reads and writes back to back so that this overlap happens several times. A scoreboard then judges the returned data against a shadow copy of the memory. A bus model records when the memory releases its outputs and flags any drive enable that comes too early. It also checks the measured latency from acceptance to the write strobe and to the drive enable.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_NS = 4,
  parameter int T_RC   = 10,
  parameter int T_AA   = 10,
  parameter int T_WC   = 10,
  parameter int T_WP   = 8,
  parameter int T_AW   = 10,
  parameter int T_DS   = 7,
  parameter int T_HZWE = 7,
  parameter int T_HZOE = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  function automatic int cyc(int t);
    int c;
    c = (t + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_C  = cyc(mx(T_RC, T_AA));
  localparam int HZW_C = cyc(T_HZWE);
  localparam int WL_C  = mx(mx(cyc(T_WP), cyc(T_AW)), mx(cyc(T_WC), HZW_C + cyc(T_DS)));
  localparam int TA_C  = cyc(T_HZOE);
  localparam int MAXC  = mx(mx(RD_C, WL_C), TA_C);
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_TA, S_WR} state_t;

  state_t        st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          last_rd, last_rd_d;
  logic          take, rd_end;

  assign take   = req_valid && (st == S_IDLE);
  assign rd_end = (st == S_RD) && (cnt == CW'(RD_C - 1));

  always_comb begin
    st_d      = st;
    cnt_d     = cnt + 1'b1;
    last_rd_d = last_rd;
    case (st)
      S_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          last_rd_d = !req_write;
          if (!req_write)   st_d = S_RD;
          else if (last_rd) st_d = S_TA;
          else              st_d = S_WR;
        end
      end
      S_RD: if (rd_end) begin
        st_d  = S_IDLE;
        cnt_d = '0;
      end
      S_TA: if (cnt == CW'(TA_C - 1)) begin
        st_d  = S_WR;
        cnt_d = '0;
      end
      default: if (cnt == CW'(WL_C - 1)) begin
        st_d  = S_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      last_rd    <= 1'b0;
      req_ready  <= 1'b1;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      st        <= st_d;
      cnt       <= cnt_d;
      last_rd   <= last_rd_d;
      req_ready <= (st_d == S_IDLE);
      mem_ce1_n <= !(st_d == S_RD || st_d == S_WR);
      mem_ce2   <= (st_d == S_RD || st_d == S_WR);
      mem_oe_n  <= (st_d != S_RD);
      mem_we_n  <= (st_d != S_WR);
      mem_dq_oe <= (st_d == S_WR) && (cnt_d >= CW'(HZW_C));
      rd_valid  <= rd_end;
      if (rd_end) rd_data <= mem_dq_in;
      if (take) begin
        mem_addr <= req_addr;
        if (req_write) mem_dq_out <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          mem_ce1_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);

  p_standby_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_rd_wr_mix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_rdvalid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  p_drive_off_at_we_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
  .mem_addr(mem_addr)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  localparam int P = 4;
  localparam int T_AA = 10, T_RC = 10, T_WP = 8, T_AW = 10, T_WC = 10;
  localparam int T_DS = 7, T_HZWE = 7, T_HZOE = 6;

  function automatic int cdiv(int t);
    int c;
    c = (t + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = cdiv(imax(T_RC, T_AA));
  localparam int E_HZ = cdiv(T_HZWE);
  localparam int E_WL = imax(imax(cdiv(T_WP), cdiv(T_AW)), imax(cdiv(T_WC), E_HZ + cdiv(T_DS)));
  localparam int E_TA = cdiv(T_HZOE);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0, mem_dq_in = 8'hEE;
  logic req_ready, rd_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dq_out;
  logic [16:0] mem_addr;

  always #2 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem_m [logic [16:0]];
  logic [7:0] shadow [logic [16:0]];
  logic [7:0] exp_q [$];
  bit   tb_last_rd = 0;
  int   exp_lat = 0;
  time  t_acc = 0, t_sel = 0, t_wf = 0, t_drv = 0, t_oe_rel = 0;
  logic p_rd_en = 0, p_we_n = 1, p_oe_n = 1, p_dq_oe = 0, p_rdv = 0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bus model and protocol monitor, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    time te;
    logic rd_en;
    te = $time - 2;
    rd_en = !mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n;
    if (rd_en && !p_rd_en) t_sel = te;
    if (!rd_en && p_rd_en) chk((te - t_sel) == E_RD * P, "R3 read window ns", te - t_sel, E_RD * P);
    if (mem_oe_n && !p_oe_n) t_oe_rel = te + T_HZOE;
    if (req_ready)
      chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 standby",
          {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    if (!mem_we_n && !mem_oe_n) chk(0, "R3 we_n and oe_n both low", 0, 1);
    if (mem_dq_oe && !p_dq_oe) begin
      t_drv = te;
      chk(!rd_en && te >= t_oe_rel, "R7 drive after memory release", te, t_oe_rel);
      chk((te - t_acc) == exp_lat * P, "R6 drive enable latency", (te - t_acc) / P, exp_lat);
    end
    if (!mem_we_n && p_we_n) begin
      t_wf = te;
      chk(!mem_ce1_n && mem_ce2 && mem_oe_n, "R5 select during write", {mem_ce1_n, mem_ce2, mem_oe_n}, 3'b011);
      chk((te - t_acc) == (exp_lat - E_HZ) * P, "R7 we fall latency", (te - t_acc) / P, exp_lat - E_HZ);
    end
    if (!mem_we_n && !p_we_n) chk(mem_addr == p_addr, "R5 address stable", mem_addr, p_addr);
    if (mem_we_n && !p_we_n) begin
      chk((te - t_wf) == E_WL * P && (te - t_wf) >= T_WP, "R5 we low ns", te - t_wf, E_WL * P);
      chk(p_dq_oe && (te - t_drv) >= T_DS, "R6 data setup ns", te - t_drv, T_DS);
      chk(!mem_dq_oe, "R6 drive off at we rise", mem_dq_oe, 0);
      mem_m[p_addr] = p_dq;
    end
    if (rd_valid) begin
      chk(!p_rdv, "R4 rd_valid one cycle", p_rdv, 0);
      if (exp_q.size() == 0) chk(0, "R4 unexpected rd_valid", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R4 read data", rd_data, e);
      end
    end
    mem_dq_in = 8'hEE;
    if (rd_en && ($time + 2 - t_sel) >= T_AA && mem_m.exists(mem_addr)) mem_dq_in = mem_m[mem_addr];
    p_rd_en = rd_en; p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
    p_rdv = rd_valid; p_addr = mem_addr; p_dq = mem_dq_out;
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    t_acc = $time + 2;
    if (wr) begin
      exp_lat = E_HZ + (tb_last_rd ? E_TA : 0);
      shadow[a] = d;
    end else exp_q.push_back(shadow[a]);
    tb_last_rd = !wr;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
        "R1 reset state", {req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b110110);
    rst_n = 1;
    @(negedge clk);
    // writes back to back, boundary addresses and data
    issue(1, 17'h00000, 8'h00);
    issue(1, 17'h1FFFF, 8'hFF);
    issue(1, 17'h00155, 8'hA5);
    issue(1, 17'h0AAAA, 8'h5A);
    // reads back to back
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h00155, 8'h00);
    // read immediately followed by write (R7 turnaround), then read back
    issue(0, 17'h0AAAA, 8'h00);
    issue(1, 17'h0AAAA, 8'h3C);
    issue(0, 17'h0AAAA, 8'h00);
    issue(1, 17'h00155, 8'hC3);
    issue(1, 17'h00156, 8'h81);
    issue(0, 17'h00155, 8'h00);
    issue(0, 17'h00156, 8'h00);
    // R2: request offered while busy must be ignored
    issue(1, 17'h00010, 8'h11);
    req_valid = 1; req_write = 1; req_addr = 17'h00155; req_wdata = 8'h77;
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    @(negedge clk);
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    req_valid = 0;
    issue(0, 17'h00155, 8'h00);
    issue(0, 17'h00010, 8'h00);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule